// File: doc/BRIEF.md
# Packed Signed Greater-Than Compare Unit

This block performs a lane-wise signed magnitude test on two packed operands, a destination and a source. A lane-width code taken from the low opcode byte splits both operands into 8-, 16- or 32-bit elements. Each destination element is compared against the source element in the same position, using two's-complement order. The result lane is filled with ones when the destination element is strictly larger. In every other case the lane is cleared.

A prefix flag picks the operand width. With the flag set, the full 128-bit vector is processed. With the flag clear, only the low 64 bits take part and the upper half of the result is forced to zero. Inputs are captured on each rising clock edge, and the result and the invalid flag appear one cycle later. No status flags are produced.

Top module: `pcmp_gt_unit`

## Requirements
- R1: Opcode byte 0x64 selects 8-bit lanes, 0x65 selects 16-bit lanes and 0x66 selects 32-bit lanes; every bit of a result lane takes the same value.
- R2: When wide_i is 1, all lanes of the 128-bit operands are compared: 16, 8 or 4 lanes for 8-, 16- or 32-bit width.
- R3: Elements are compared as two's-complement signed values. For example, 8-bit 0x01 is greater than 0x80, but 0x80 is not greater than 0x01.
- R4: A lane whose destination element is strictly greater than the source element becomes all ones; equal or smaller gives all zeros, including the most negative value compared with itself.
- R5: When wide_i is 0, only bits 63:0 are compared (8, 4 or 2 lanes) and result bits 127:64 are zero.
- R6: An opcode byte other than 0x64, 0x65 or 0x66 sets invalid_o to 1 and the result to all zeros; a valid opcode gives invalid_o 0.
- R7: result_o and invalid_o reflect the inputs sampled at the previous rising clock edge.
- R8: While rst_ni is low, result_o is zero and invalid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 8 | Low opcode byte that selects the lane width |
| wide_i | input | 1 | 1: 128-bit operands, 0: 64-bit operands |
| dst_i | input | 128 | Destination operand |
| src_i | input | 128 | Source operand |
| result_o | output | 128 | Per-lane compare mask |
| invalid_o | output | 1 | Opcode byte not recognised |

## Verification
Because the unit holds only one pipeline register, a fault in width decode or lane selection appears on the very next cycle. It can show up as a lane that is only partly set, as mask bits that straddle a lane boundary, or as nonzero upper bits in 64-bit mode. A sign-handling error shows only on lanes whose operands differ in their top bit, so those lanes, equal lanes and lanes holding the most negative value are driven on purpose. Invalid opcodes are mixed into the random stream so that a result leaking past the invalid flag is caught in the cycle that follows.

// File: rtl/pcmp_gt_pkg.sv
package pcmp_gt_pkg;
  typedef enum logic [1:0] {
    LANE_NONE = 2'd0,
    LANE_8    = 2'd1,
    LANE_16   = 2'd2,
    LANE_32   = 2'd3
  } lane_sel_e;

  localparam logic [7:0] OPC_GT8  = 8'h64;
  localparam logic [7:0] OPC_GT16 = 8'h65;
  localparam logic [7:0] OPC_GT32 = 8'h66;
endpackage

// File: rtl/pcmp_gt_decode.sv
module pcmp_gt_decode
  import pcmp_gt_pkg::*;
(
  input  logic [7:0] opcode_i,
  output lane_sel_e  sel_o,
  output logic       invalid_o
);
  always_comb begin
    invalid_o = 1'b0;
    case (opcode_i)
      OPC_GT8:  sel_o = LANE_8;
      OPC_GT16: sel_o = LANE_16;
      OPC_GT32: sel_o = LANE_32;
      default: begin
        sel_o     = LANE_NONE;
        invalid_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pcmp_gt_lanes.sv
module pcmp_gt_lanes #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8,
  localparam int NUM_LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0]    dst_i,
  input  logic [DATA_W-1:0]    src_i,
  output logic [NUM_LANES-1:0] gt_o
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic signed [LANE_W-1:0] d_s, s_s;
    assign d_s     = dst_i[i*LANE_W +: LANE_W];
    assign s_s     = src_i[i*LANE_W +: LANE_W];
    assign gt_o[i] = d_s > s_s;
  end
endmodule

// File: rtl/pcmp_gt_mask.sv
module pcmp_gt_mask
  import pcmp_gt_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64,
  localparam int NB = DATA_W / 8,
  localparam int NW = DATA_W / 16,
  localparam int ND = DATA_W / 32,
  localparam int NARROW_B = NARROW_W / 8
) (
  input  lane_sel_e         sel_i,
  input  logic              wide_i,
  input  logic [NB-1:0]     gt8_i,
  input  logic [NW-1:0]     gt16_i,
  input  logic [ND-1:0]     gt32_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic hit, live;
    always_comb begin
      case (sel_i)
        LANE_8:  hit = gt8_i[k];
        LANE_16: hit = gt16_i[k/2];
        LANE_32: hit = gt32_i[k/4];
        default: hit = 1'b0;
      endcase
    end
    // upper half stays zero for 64-bit operations
    if (k < NARROW_B) begin : g_low
      assign live = 1'b1;
    end else begin : g_high
      assign live = wide_i;
    end
    assign mask_o[k*8 +: 8] = {8{hit & live}};
  end
endmodule

// File: rtl/pcmp_gt_unit.sv
module pcmp_gt_unit
  import pcmp_gt_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        opcode_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] result_o,
  output logic              invalid_o
);
  localparam int NB = DATA_W / 8;
  localparam int NW = DATA_W / 16;
  localparam int ND = DATA_W / 32;

  lane_sel_e         sel;
  logic              bad_opc;
  logic [NB-1:0]     gt8;
  logic [NW-1:0]     gt16;
  logic [ND-1:0]     gt32;
  logic [DATA_W-1:0] mask;

  pcmp_gt_decode u_dec (
    .opcode_i (opcode_i),
    .sel_o    (sel),
    .invalid_o(bad_opc)
  );

  pcmp_gt_lanes #(.DATA_W(DATA_W), .LANE_W(8)) u_cmp8 (
    .dst_i(dst_i), .src_i(src_i), .gt_o(gt8)
  );
  pcmp_gt_lanes #(.DATA_W(DATA_W), .LANE_W(16)) u_cmp16 (
    .dst_i(dst_i), .src_i(src_i), .gt_o(gt16)
  );
  pcmp_gt_lanes #(.DATA_W(DATA_W), .LANE_W(32)) u_cmp32 (
    .dst_i(dst_i), .src_i(src_i), .gt_o(gt32)
  );

  pcmp_gt_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_mask (
    .sel_i (sel),
    .wide_i(wide_i),
    .gt8_i (gt8),
    .gt16_i(gt16),
    .gt32_i(gt32),
    .mask_o(mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      result_o  <= mask;
      invalid_o <= bad_opc;
    end
  end
endmodule

// File: rtl/pcmp_gt_chk.sv
module pcmp_gt_chk #(
  parameter int DATA_W   = 128,
  parameter int NARROW_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        opcode_i,
  input logic              wide_i,
  input logic [DATA_W-1:0] result_o,
  input logic              invalid_o
);
  localparam int NB = DATA_W / 8;

  logic armed;
  logic bytes_uniform;
  logic words_paired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  always_comb begin
    bytes_uniform = 1'b1;
    for (int k = 0; k < NB; k++) begin
      if (result_o[k*8 +: 8] != 8'h00 && result_o[k*8 +: 8] != 8'hFF) bytes_uniform = 1'b0;
    end
  end

  always_comb begin
    words_paired = 1'b1;
    for (int k = 0; k < NB/2; k++) begin
      if (result_o[k*16 +: 8] != result_o[k*16+8 +: 8]) words_paired = 1'b0;
    end
  end

  // R8
  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !invalid_o));

  a_r6_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> result_o == '0);

  a_r6_flag_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> invalid_o == !($past(opcode_i) inside {8'h64, 8'h65, 8'h66}));

  a_r5_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(wide_i)) |-> result_o[DATA_W-1:NARROW_W] == '0);

  a_r1_byte_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> bytes_uniform);

  a_r1_word_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(opcode_i) == 8'h65) |-> words_paired);
endmodule

bind pcmp_gt_unit pcmp_gt_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opcode_i (opcode_i),
  .wide_i   (wide_i),
  .result_o (result_o),
  .invalid_o(invalid_o)
);

// File: tb/pcmp_gt_unit_tb_top.sv
module pcmp_gt_unit_tb_top;
  localparam int DW = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    opcode_i = 8'h00;
  logic          wide_i = 1'b0;
  logic [DW-1:0] dst_i = '0;
  logic [DW-1:0] src_i = '0;
  logic [DW-1:0] result_o;
  logic          invalid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pcmp_gt_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .opcode_i(opcode_i), .wide_i(wide_i),
    .dst_i(dst_i), .src_i(src_i), .result_o(result_o), .invalid_o(invalid_o)
  );

  function automatic int lane_bits(logic [7:0] op);
    if (op == 8'h64) return 8;
    if (op == 8'h65) return 16;
    if (op == 8'h66) return 32;
    return 0;
  endfunction

  // independent model: signed order via sign-bit flip then unsigned compare
  function automatic logic [DW-1:0] model(logic [7:0] op, logic w,
                                          logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r = '0;
    int lw = lane_bits(op);
    int span = w ? 128 : 64;
    if (lw == 0) return '0;
    for (int i = 0; i < span / lw; i++) begin
      logic [31:0] x = 32'(a >> (i*lw));
      logic [31:0] y = 32'(b >> (i*lw));
      logic [31:0] m = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 1);
      logic [31:0] sb = 32'd1 << (lw-1);
      x = (x & m) ^ sb;
      y = (y & m) ^ sb;
      if (x > y) r = r | ({{(DW-32){1'b0}}, m} << (i*lw));
    end
    return r;
  endfunction

  task automatic check(string req, logic [7:0] op, logic w,
                       logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] er;
    logic ei;
    @(negedge clk_i);
    opcode_i = op; wide_i = w; dst_i = a; src_i = b;
    er = model(op, w, a, b);
    ei = (lane_bits(op) == 0);
    @(posedge clk_i);
    #1;
    n_chk++;
    if (result_o !== er || invalid_o !== ei) begin
      n_bad++;
      $display("FAIL %s op=%h w=%0d result=%h inv=%0d expected=%h inv=%0d",
               req, op, w, result_o, invalid_o, er, ei);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #5;
    n_chk++;
    if (result_o !== '0 || invalid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 reset result=%h inv=%0d expected=0 inv=0", result_o, invalid_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R3 signed: 0x01 > 0x80 in byte lanes, reverse is not
    check("R3", 8'h64, 1'b1, {16{8'h01}}, {16{8'h80}});
    check("R3", 8'h64, 1'b1, {16{8'h80}}, {16{8'h01}});
    check("R3", 8'h65, 1'b1, {8{16'h0000}}, {8{16'hFFFF}});
    check("R3", 8'h66, 1'b1, {4{32'h7FFF_FFFF}}, {4{32'h8000_0000}});
    // R4 equal and most-negative self compare
    check("R4", 8'h64, 1'b1, {16{8'h80}}, {16{8'h80}});
    check("R4", 8'h66, 1'b1, {4{32'h8000_0000}}, {4{32'h8000_0000}});
    check("R4", 8'h65, 1'b1, {8{16'h1234}}, {8{16'h1234}});
    // R1 lane widths: same data, boundary-sensitive pattern
    check("R1", 8'h64, 1'b1, 128'h00FF_00FF_0100_7F80_0001_FFFE_8000_0102,
                             128'h0000_0000_00FF_807F_0100_FEFF_7FFF_0201);
    check("R1", 8'h65, 1'b1, 128'h00FF_00FF_0100_7F80_0001_FFFE_8000_0102,
                             128'h0000_0000_00FF_807F_0100_FEFF_7FFF_0201);
    check("R1", 8'h66, 1'b1, 128'h00FF_00FF_0100_7F80_0001_FFFE_8000_0102,
                             128'h0000_0000_00FF_807F_0100_FEFF_7FFF_0201);
    // R2 / R5 all lanes greater, wide vs narrow
    check("R2", 8'h64, 1'b1, {16{8'h05}}, {16{8'h03}});
    check("R5", 8'h64, 1'b0, {16{8'h05}}, {16{8'h03}});
    check("R5", 8'h66, 1'b0, {4{32'h0000_0009}}, {4{32'hFFFF_FFF0}});
    // R6 invalid opcodes
    check("R6", 8'h67, 1'b1, {16{8'h05}}, {16{8'h03}});
    check("R6", 8'h63, 1'b0, {16{8'h05}}, {16{8'h03}});
    check("R6", 8'hE4, 1'b1, {16{8'h7F}}, '0);
    // R7 back-to-back changes, each cycle checked
    for (int i = 0; i < 600; i++) begin
      logic [7:0] op;
      logic [DW-1:0] a, b;
      int sel = $urandom_range(0, 9);
      op = (sel < 3) ? 8'h64 : (sel < 6) ? 8'h65 : (sel < 9) ? 8'h66 : 8'($urandom);
      a = {$urandom, $urandom, $urandom, $urandom};
      b = (i % 7 == 0) ? a : {$urandom, $urandom, $urandom, $urandom};
      check((i % 2) ? "R7" : "R2", op, 1'($urandom), a, b);
    end
    // R8 asynchronous reset clears outputs mid-run
    check("R8", 8'h64, 1'b1, {16{8'h05}}, {16{8'h03}});
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    n_chk++;
    if (result_o !== '0 || invalid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 async reset result=%h inv=%0d expected=0 inv=0", result_o, invalid_o);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule